// File: doc/BRIEF.md
# DRAM Address Hold-Delay Generator

This block produces the short hold delays that a retro DRAM controller needs around its address multiplexer. Its time base is a free-running oscillator of about 48 MHz, a period of roughly 20.8 ns. That oscillator is asynchronous to the system timing. The block watches the row strobe, the Q3 timing strobe and the PHI_0 phase input. It also takes the undelayed 80-column enable and the two ROM enables. From these it produces delayed copies that land inside fixed nanosecond hold windows.

Every input first passes through a two-flop synchronizer. Each delayed output is then driven by its own tick counter.

- **Row qualifier `col_ok`:** rises a set number of ticks after the row strobe falls, and only in the phase chosen by a parameter. It drops soon after the strobe rises. The address mux uses it to switch from the row address to the column address.
- **Column hold `q3_dly`:** a delayed copy of Q3. The column address may change once `q3_dly` follows Q3.
- **Enable outputs:** the 80-column enable and, when `ROM_DLY` is set, the two ROM enables are re-sampled a fixed number of ticks after each PHI_0 transition.

**Timing.** An input change arrives at some random point within a tick. So the delay from the input to the output of a counter set to N ticks is between N+1 and N+2 oscillator periods.

**Defaults.** All counts default to one tick, which gives about 42 to 62 ns. That lands inside every window:
- row hold: 32 to 80 ns
- column hold: 20 to about 275 ns
- 80-column enable: about 45 ns

Top module: `hold_delay_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every delayed output equals the synchronized value of its input (`col_ok` equals the inverted row strobe, so it is low while the strobe is high).
- R2: When the synchronized row strobe falls while synchronized PHI_0 equals `RAS_PHASE`, `col_ok` rises at the (ROW_TICKS+2)-th rising oscillator edge after the strobe changes.
- R3: A row strobe fall while PHI_0 is in the other phase leaves `col_ok` low.
- R4: `col_ok` goes low at the third rising edge after the row strobe rises.
- R5: `q3_dly` takes each new Q3 level at the (COL_TICKS+2)-th rising edge after Q3 changes.
- R6: `en80_n_dly` changes only at the (EN80_TICKS+2)-th rising edge after a PHI_0 transition, taking the synchronized enable present then. A change of the enable alone does not move it.
- R7: With `ROM_DLY`=1 the ROM outputs behave as in R6 with ROM_TICKS. With `ROM_DLY`=0 each ROM output follows its input at the second rising edge, with no PHI_0 edge needed.
- R8: A trigger that arrives while a count is running reloads the counter. The output then ends at the most recent input value, so a Q3 pulse shorter than the count never appears on `q3_dly`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator, the time base |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| q3 | input | 1 | Q3 timing strobe, asynchronous |
| phi0 | input | 1 | PHI_0 phase, asynchronous |
| en80_n | input | 1 | Undelayed 80-column enable |
| rom1_n | input | 1 | Undelayed first ROM enable |
| rom2_n | input | 1 | Undelayed second ROM enable |
| col_ok | output | 1 | High once the row hold has elapsed |
| q3_dly | output | 1 | Q3 delayed by the column hold |
| en80_n_dly | output | 1 | 80-column enable re-timed after PHI_0 edges |
| rom1_n_dly | output | 1 | First ROM enable, delayed or passed through |
| rom2_n_dly | output | 1 | Second ROM enable, delayed or passed through |

## Verification
Two instances run side by side:
- one with PHI_0 arming the row delay, one-tick counts and delayed ROM enables;
- one with PHI_1 arming, longer counts and pass-through ROM enables.

Each input change is made at a random offset inside the tick. The bench then records the edge at which each output first moves.

- **Row strobe falls in each phase:** tells a correct arming phase from an inverted or missing phase guard.
- **Enable changes with no PHI_0 edge:** tells true re-timing from a plain delay line.
- **Q3 pulses shorter than the count:** tell a restarting counter from one that runs out and shows a stale pulse.

The measured edge counts also expose any extra or missing register stage.

// File: rtl/hold_pkg.sv
package hold_pkg;
    localparam int MAX_TICKS = 12;
    localparam int TICK_W    = $clog2(MAX_TICKS + 1);
    typedef logic [TICK_W-1:0] tick_t;

    typedef struct packed {
        tick_t cnt;
        logic  lvl;
    } dly_st_t;

    // bit positions inside the synchronizer bundle
    localparam int IX_RAS  = 0;
    localparam int IX_Q3   = 1;
    localparam int IX_PHI  = 2;
    localparam int IX_EN80 = 3;
    localparam int IX_ROM1 = 4;
    localparam int IX_ROM2 = 5;
    localparam int N_IN    = 6;
endpackage

// File: rtl/in_sync.sv
module in_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] edge_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta = din;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.sync;
    assign edge_o = st_q.sync ^ st_q.prev;
endmodule

// File: rtl/dly_unit.sv
module dly_unit
    import hold_pkg::*;
#(
    parameter int TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic clr,
    input  logic val,
    output logic lvl_o
);
    localparam tick_t LOAD = tick_t'(TICKS - 1);

    dly_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || clr) begin
            st_d.cnt = '0;
            st_d.lvl = val;
        end else if (trig) begin
            st_d.cnt = LOAD;
            if (TICKS == 1) st_d.lvl = val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - tick_t'(1);
            if (st_q.cnt == tick_t'(1)) st_d.lvl = val;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    // R8: a trigger always (re)loads the full count
    a_r8_reload: assert property (@(posedge clk) disable iff (rst)
        (trig && !clr) |=> (st_q.cnt == LOAD));

    // R6: with no trigger and no running count the output holds
    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        (!trig && !clr && st_q.cnt == '0) |=> $stable(lvl_o));

    // R5: the counter never exceeds its configured load
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LOAD);

    initial begin
        a_r5_ticks_legal: assert (TICKS >= 1 && TICKS <= MAX_TICKS);
    end
endmodule

// File: rtl/hold_delay_gen.sv
module hold_delay_gen
    import hold_pkg::*;
#(
    parameter int ROW_TICKS  = 1,
    parameter int COL_TICKS  = 1,
    parameter int EN80_TICKS = 1,
    parameter int ROM_TICKS  = 1,
    parameter bit RAS_PHASE  = 1'b1,
    parameter bit ROM_DLY    = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ras_n,
    input  logic q3,
    input  logic phi0,
    input  logic en80_n,
    input  logic rom1_n,
    input  logic rom2_n,
    output logic col_ok,
    output logic q3_dly,
    output logic en80_n_dly,
    output logic rom1_n_dly,
    output logic rom2_n_dly
);
    logic [N_IN-1:0] raw, s, e;
    logic            ras_fall, ras_rise, phase_ok;
    logic [1:0]      rom_dly;

    assign raw[IX_RAS]  = ras_n;
    assign raw[IX_Q3]   = q3;
    assign raw[IX_PHI]  = phi0;
    assign raw[IX_EN80] = en80_n;
    assign raw[IX_ROM1] = rom1_n;
    assign raw[IX_ROM2] = rom2_n;

    in_sync #(.W(N_IN)) u_sync (
        .clk    (clk),
        .din    (raw),
        .sync_o (s),
        .edge_o (e)
    );

    assign ras_fall = e[IX_RAS] & ~s[IX_RAS];
    assign ras_rise = e[IX_RAS] &  s[IX_RAS];
    assign phase_ok = (s[IX_PHI] == RAS_PHASE);

    // R2 R3 R4: row hold, armed only in the chosen phase
    dly_unit #(.TICKS(ROW_TICKS)) u_row (
        .clk   (clk),
        .rst   (rst),
        .trig  (ras_fall & phase_ok),
        .clr   (ras_rise),
        .val   (~s[IX_RAS]),
        .lvl_o (col_ok)
    );

    // R5: column hold after each Q3 edge
    dly_unit #(.TICKS(COL_TICKS)) u_col (
        .clk   (clk),
        .rst   (rst),
        .trig  (e[IX_Q3]),
        .clr   (1'b0),
        .val   (s[IX_Q3]),
        .lvl_o (q3_dly)
    );

    // R6: 80-column enable re-timed after PHI_0 transitions
    dly_unit #(.TICKS(EN80_TICKS)) u_en80 (
        .clk   (clk),
        .rst   (rst),
        .trig  (e[IX_PHI]),
        .clr   (1'b0),
        .val   (s[IX_EN80]),
        .lvl_o (en80_n_dly)
    );

    // R7: ROM enables, delayed or passed straight through
    for (genvar i = 0; i < 2; i++) begin : g_rom
        if (ROM_DLY) begin : g_dly
            dly_unit #(.TICKS(ROM_TICKS)) u_rom (
                .clk   (clk),
                .rst   (rst),
                .trig  (e[IX_PHI]),
                .clr   (1'b0),
                .val   (s[IX_ROM1 + i]),
                .lvl_o (rom_dly[i])
            );
        end else begin : g_thru
            assign rom_dly[i] = s[IX_ROM1 + i];
        end
    end

    assign rom1_n_dly = rom_dly[0];
    assign rom2_n_dly = rom_dly[1];

    // R3: a fall in the wrong phase never raises the qualifier
    a_r3_phase_guard: assert property (@(posedge clk) disable iff (rst)
        (ras_fall && !phase_ok && !col_ok) |=> !col_ok);

    // R4: a strobe rise drops the qualifier on the next edge
    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        ras_rise |=> !col_ok);

    // R1: during reset the qualifier mirrors the inverted strobe
    a_r1_reset_mirror: assert property (@(posedge clk)
        rst |=> (col_ok == ~$past(s[IX_RAS])));
endmodule

// File: tb/hold_delay_gen_tb.sv
module hold_delay_gen_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, q3 = 1'b0, phi0 = 1'b0;
    logic en80_n = 1'b1, rom1_n = 1'b1, rom2_n = 1'b1;

    logic [4:0] o_a, o_b;
    logic [9:0] obs;
    int lat [10];
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // main instance: PHI_0 arming, one-tick counts, delayed ROM enables
    hold_delay_gen u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .q3(q3), .phi0(phi0),
        .en80_n(en80_n), .rom1_n(rom1_n), .rom2_n(rom2_n),
        .col_ok(o_a[0]), .q3_dly(o_a[1]), .en80_n_dly(o_a[2]),
        .rom1_n_dly(o_a[3]), .rom2_n_dly(o_a[4])
    );

    // variant: PHI_1 arming, longer counts, pass-through ROM enables
    hold_delay_gen #(
        .ROW_TICKS(3), .COL_TICKS(2), .EN80_TICKS(2),
        .RAS_PHASE(1'b0), .ROM_DLY(1'b0)
    ) u_alt (
        .clk(clk), .rst(rst), .ras_n(ras_n), .q3(q3), .phi0(phi0),
        .en80_n(en80_n), .rom1_n(rom1_n), .rom2_n(rom2_n),
        .col_ok(o_b[0]), .q3_dly(o_b[1]), .en80_n_dly(o_b[2]),
        .rom1_n_dly(o_b[3]), .rom2_n_dly(o_b[4])
    );

    assign obs = {o_b, o_a};

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // change inputs at a random offset inside the tick
    task automatic wait_drive();
        @(posedge clk);
        #(3 + ($urandom % 4));
    endtask

    // record the first edge (1-based) at which each output moves
    task automatic measure();
        logic [9:0] base;
        base = obs;
        for (int b = 0; b < 10; b++) lat[b] = 0;
        for (int n = 1; n <= 20; n++) begin
            @(posedge clk);
            #2;
            for (int b = 0; b < 10; b++)
                if (lat[b] == 0 && obs[b] != base[b]) lat[b] = n;
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #3 rst = 1'b0;
        @(posedge clk);
        #2;
        chk("R1 main reset outputs", int'(o_a), 5'b11100);
        chk("R1 alt reset outputs", int'(o_b), 5'b11100);

        // PHI_0 low: only the PHI_1 variant arms
        wait_drive(); ras_n = 1'b0; measure();
        chk("R3 main col_ok stays low", lat[0], 0);
        chk("R2 alt col_ok rise edge", lat[5], 5);
        chk("R2 alt col_ok level", o_b[0], 1);
        wait_drive(); ras_n = 1'b1; measure();
        chk("R4 alt col_ok fall edge", lat[5], 3);

        // enable changes without a PHI_0 edge
        wait_drive(); en80_n = 1'b0; rom1_n = 1'b0; measure();
        chk("R6 main en80 no phi edge", lat[2], 0);
        chk("R6 alt en80 no phi edge", lat[7], 0);
        chk("R7 main rom1 no phi edge", lat[3], 0);
        chk("R7 alt rom1 pass-through edge", lat[8], 2);

        wait_drive(); phi0 = 1'b1; measure();
        chk("R6 main en80 edge", lat[2], 3);
        chk("R6 main en80 level", o_a[2], 0);
        chk("R6 alt en80 edge", lat[7], 4);
        chk("R7 main rom1 edge", lat[3], 3);
        chk("R7 main rom2 unchanged", lat[4], 0);

        // PHI_0 high: only the main instance arms
        wait_drive(); ras_n = 1'b0; measure();
        chk("R2 main col_ok rise edge", lat[0], 3);
        chk("R3 alt col_ok stays low", lat[5], 0);
        wait_drive(); ras_n = 1'b1; measure();
        chk("R4 main col_ok fall edge", lat[0], 3);

        // column hold, both directions
        wait_drive(); q3 = 1'b1; measure();
        chk("R5 main q3 rise edge", lat[1], 3);
        chk("R5 alt q3 rise edge", lat[6], 4);
        wait_drive(); q3 = 1'b0; measure();
        chk("R5 main q3 fall edge", lat[1], 3);
        chk("R5 alt q3 fall edge", lat[6], 4);

        // short Q3 pulse: the variant restarts and never shows it
        wait_drive(); q3 = 1'b1;
        wait_drive(); q3 = 1'b0; measure();
        chk("R8 alt short pulse hidden", lat[6], 0);
        chk("R8 alt q3 final", o_b[1], 0);
        chk("R8 main q3 final", o_a[1], 0);

        // two PHI_0 edges back to back, enable changed with the second
        wait_drive(); phi0 = 1'b0;
        wait_drive(); phi0 = 1'b1; en80_n = 1'b1; measure();
        chk("R8 alt en80 follows latest edge", lat[7], 4);
        chk("R8 alt en80 level", o_b[2], 1);
        chk("R6 main en80 follows latest edge", lat[2], 3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule